// File: doc/BRIEF.md
# Key-locked system control register bank

This block is a bank of 32-bit control and status words inside a 4 KiB byte window. It is reached over a plain single-cycle bus made of a select, a write enable, a byte address, write data, read data and an error flag. The word index is the byte address divided by four, so address bits 1:0 are ignored. Read data and the error flag are combinational from the address in the same cycle. A write takes effect at the clock edge that ends the access cycle.

Ordinary read/write words are protected by a lock. The bank leaves reset locked. A write with a 16-bit unlock key to a key register opens the bank, and a write with a different key to another key register closes it again. Each word has an access class: read/write, read-only, write-only or unmapped. Any access that breaks its class is flagged. Read-only status words are taken straight from input ports. Setting bit 0 in the reset-control word raises a one-cycle soft-reset request.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, the lock status word (0x00C, bit 0) reads 1. The PLL control words at 0x100, 0x104 and 0x108 read 0x0001A008, the reset-reason word (0x250) reads 0x00000040, the reset-control word (0x200) reads 0, and the scratch bit reads 0.
- R2: A write to 0x004 whose data bits 15:0 equal 0x767B sets the lock. A write to 0x004 with any other value in bits 15:0 leaves the lock state unchanged.
- R3: A write to 0x008 whose data bits 15:0 equal 0xDF0D clears the lock. A write to 0x008 with any other value in bits 15:0 leaves the lock state unchanged.
- R4: While the bank is locked, a write to a read/write word is discarded and raises no error. While the bank is unlocked, such a write is stored.
- R5: The word at 0x000 stores only bit 0 of the write data. Writes to it are accepted whether the bank is locked or not, and reads return the stored bit in bit 0 with zeros in bits 31:1.
- R6: An accepted write to 0x200 with data bit 0 set drives the soft-reset request high for exactly the one cycle after the write edge. The request stays low if the bank is locked or if bit 0 is clear.
- R7: Read-only words return their input ports: 0x10C the PLL status, 0x25C the boot mode, 0x530 the identity code, 0x618 the DDR command status and 0x61C the DDR interface status. These reads raise no error.
- R8: The write-only words are 0x004, 0x008, 0x60C and 0x614. A read of one of them returns 0 and raises the error flag. A write to 0x60C or 0x614 raises no error.
- R9: A write to a read-only word raises the error flag and changes nothing. Any access to an unmapped word raises the error flag, and a read of an unmapped word returns 0.
- R10: The pad configuration words at 0x700 + 4*i, for i from 0 to NUM_PADS-1 (default 54), are read/write. They reset to 0x00001601, except indices 2 to 8, which reset to 0x00000601. The word just past the last pad is unmapped.
- R11: Read data and the error flag are valid in the same cycle as the address. A stored write is visible to a read in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_err | output | 1 | Access error, combinational |
| pll_stat_i | input | 32 | PLL status word |
| boot_mode_i | input | 32 | Boot mode word |
| id_code_i | input | 32 | Identity code word |
| ddr_cmd_stat_i | input | 32 | DDR command status word |
| ddr_dfi_stat_i | input | 32 | DDR interface status word |
| soft_rst_req_o | output | 1 | One-cycle soft-reset request |

## Verification
Read data and the error flag have no register on their path. The bench therefore samples them 1 ns after it drives the address, still in the same cycle. The lock state, the stored words and the soft-reset request each change at the one clock edge that ends a write. The bench samples the request at the following falling edge, and confirms it has dropped one cycle later. A stored value is checked by a read in a later cycle. Ignored key writes and locked writes are checked the same way: the lock status word or the target word is read back right after the write.

// File: rtl/sysctl_regbank.sv
module sysctl_regbank #(
  parameter int          NUM_PADS   = 54,
  parameter logic [15:0] LOCK_KEY   = 16'h767B,
  parameter logic [15:0] UNLOCK_KEY = 16'hDF0D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_err,
  input  logic [31:0] pll_stat_i,
  input  logic [31:0] boot_mode_i,
  input  logic [31:0] id_code_i,
  input  logic [31:0] ddr_cmd_stat_i,
  input  logic [31:0] ddr_dfi_stat_i,
  output logic        soft_rst_req_o
);

  localparam int PAD_IW = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;
  localparam int NUM_PLL = 3;

  localparam logic [9:0] I_SCR  = 10'd0;
  localparam logic [9:0] I_LOCK = 10'd1;
  localparam logic [9:0] I_UNLK = 10'd2;
  localparam logic [9:0] I_LSTA = 10'd3;
  localparam logic [9:0] I_PLL0 = 10'd64;
  localparam logic [9:0] I_PSTA = 10'd67;
  localparam logic [9:0] I_RCTL = 10'd128;
  localparam logic [9:0] I_RRSN = 10'd148;
  localparam logic [9:0] I_BOOT = 10'd151;
  localparam logic [9:0] I_ID   = 10'd332;
  localparam logic [9:0] I_CAL  = 10'd387;
  localparam logic [9:0] I_REF  = 10'd389;
  localparam logic [9:0] I_CMDS = 10'd390;
  localparam logic [9:0] I_DFIS = 10'd391;
  localparam logic [9:0] I_PAD0 = 10'd448;
  localparam logic [9:0] I_PADE = I_PAD0 + 10'(NUM_PADS);

  typedef enum logic [1:0] {ACC_NONE, ACC_RW, ACC_RO, ACC_WO} acc_e;

  logic [9:0]  idx;
  acc_e        cls;
  logic        is_pad, is_pll;
  logic [PAD_IW-1:0] pad_i;
  logic [1:0]  pll_i;

  logic        locked;
  logic        scratch;
  logic [31:0] pll_q [NUM_PLL];
  logic [31:0] rctl_q, rrsn_q;
  logic [31:0] pad_q [NUM_PADS];

  logic        wr_legal, wr_store;

  assign idx    = bus_addr[11:2];
  assign is_pad = (idx >= I_PAD0) && (idx < I_PADE);
  assign is_pll = (idx >= I_PLL0) && (idx < I_PLL0 + 10'(NUM_PLL));
  assign pad_i  = PAD_IW'(idx - I_PAD0);
  assign pll_i  = 2'(idx - I_PLL0);

  function automatic logic [31:0] pad_reset(int i);
    return (i >= 2 && i <= 8) ? 32'h0000_0601 : 32'h0000_1601;
  endfunction

  always_comb begin
    if (is_pad || is_pll) cls = ACC_RW;
    else begin
      case (idx)
        I_SCR, I_RCTL, I_RRSN:                  cls = ACC_RW;
        I_LOCK, I_UNLK, I_CAL, I_REF:           cls = ACC_WO;
        I_LSTA, I_PSTA, I_BOOT, I_ID,
        I_CMDS, I_DFIS:                         cls = ACC_RO;
        default:                                cls = ACC_NONE;
      endcase
    end
  end

  assign bus_err  = bus_sel && ((cls == ACC_NONE) ||
                                ( bus_we && cls == ACC_RO) ||
                                (!bus_we && cls == ACC_WO));
  assign wr_legal = bus_sel && bus_we && !bus_err;
  assign wr_store = wr_legal && cls == ACC_RW && (!locked || idx == I_SCR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked <= 1'b1;
    else if (wr_legal && idx == I_LOCK && bus_wdata[15:0] == LOCK_KEY) locked <= 1'b1;
    else if (wr_legal && idx == I_UNLK && bus_wdata[15:0] == UNLOCK_KEY) locked <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch        <= 1'b0;
      rctl_q         <= '0;
      rrsn_q         <= 32'h0000_0040;
      soft_rst_req_o <= 1'b0;
      for (int k = 0; k < NUM_PLL; k++) pll_q[k] <= 32'h0001_A008;
    end else begin
      soft_rst_req_o <= wr_store && idx == I_RCTL && bus_wdata[0];
      if (wr_store) begin
        if (idx == I_SCR)  scratch <= bus_wdata[0];
        if (idx == I_RCTL) rctl_q  <= bus_wdata;
        if (idx == I_RRSN) rrsn_q  <= bus_wdata;
        if (is_pll)        pll_q[pll_i] <= bus_wdata;
      end
    end
  end

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pad_q[g] <= pad_reset(g);
      else if (wr_store && is_pad && pad_i == PAD_IW'(g)) pad_q[g] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (is_pad)      bus_rdata = pad_q[pad_i];
    else if (is_pll) bus_rdata = pll_q[pll_i];
    else begin
      case (idx)
        I_SCR:  bus_rdata = {31'b0, scratch};
        I_LSTA: bus_rdata = {31'b0, locked};
        I_PSTA: bus_rdata = pll_stat_i;
        I_RCTL: bus_rdata = rctl_q;
        I_RRSN: bus_rdata = rrsn_q;
        I_BOOT: bus_rdata = boot_mode_i;
        I_ID:   bus_rdata = id_code_i;
        I_CMDS: bus_rdata = ddr_cmd_stat_i;
        I_DFIS: bus_rdata = ddr_dfi_stat_i;
        default: bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_err,
  input logic        soft_rst_req_o,
  input logic        locked,
  input logic        scratch,
  input logic [31:0] pll0
);

  a_r2_lock_key: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr[11:2] == 10'd1 && bus_wdata[15:0] == 16'h767B) |=> locked);

  a_r3_unlock_key: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr[11:2] == 10'd2 && bus_wdata[15:0] == 16'hDF0D) |=> !locked);

  a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr[11:2] == 10'd64 && locked) |=> $stable(pll0));

  a_r5_scratch_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr[11:2] == 10'd0) |=> (scratch == $past(bus_wdata[0])));

  a_r6_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req_o |-> $past(bus_sel && bus_we && bus_addr[11:2] == 10'd128 &&
                             bus_wdata[0] && !locked));

  a_r9_ro_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr[11:2] == 10'd67) |-> bus_err);

endmodule

bind sysctl_regbank sysctl_regbank_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_err(bus_err),
  .soft_rst_req_o(soft_rst_req_o), .locked(locked), .scratch(scratch),
  .pll0(pll_q[0])
);

// File: tb/test_sysctl_regbank.sv
`timescale 1ns/1ps
module test_sysctl_regbank;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_err, soft_rst_req_o;
  logic [31:0] pll_stat_i = 32'h0000_003F, boot_mode_i = 32'h0000_0001;
  logic [31:0] id_code_i = 32'h1372_3093, ddr_cmd_stat_i = 32'h0000_00A5;
  logic [31:0] ddr_dfi_stat_i = 32'h0000_005A;

  int n_run = 0, n_fail = 0;
  logic [31:0] rd_v;
  logic rd_e, wr_e, wr_p;

  always #5 clk = ~clk;

  sysctl_regbank i_sysctl_regbank (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(logic [11:0] a);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 rd_v = bus_rdata; rd_e = bus_err;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    #1 wr_e = bus_err;
    @(negedge clk); wr_p = soft_rst_req_o; bus_sel = 0; bus_we = 0;
  endtask

  task automatic t_reset;
    rd(12'h00C); chk("R1 lock status", rd_v, 32'h1);
    for (int i = 0; i < 3; i++) begin
      rd(12'h100 + 12'(4*i)); chk("R1 pll ctrl", rd_v, 32'h0001_A008);
    end
    rd(12'h250); chk("R1 reset reason", rd_v, 32'h40);
    rd(12'h200); chk("R1 reset ctrl", rd_v, 32'h0);
    rd(12'h000); chk("R1 scratch", rd_v, 32'h0);
    rd(12'h700); chk("R10 pad0 reset", rd_v, 32'h1601);
    rd(12'h708); chk("R10 pad2 reset", rd_v, 32'h0601);
    rd(12'h720); chk("R10 pad8 reset", rd_v, 32'h0601);
    rd(12'h724); chk("R10 pad9 reset", rd_v, 32'h1601);
  endtask

  task automatic t_locked;
    wr(12'h104, 32'h1234_5678); chk("R4 locked write no err", 32'(wr_e), 32'h0);
    rd(12'h104); chk("R4 locked write discarded", rd_v, 32'h0001_A008);
    wr(12'h000, 32'hFFFF_FFFE); rd(12'h000); chk("R5 scratch bit0 only", rd_v, 32'h0);
    wr(12'h000, 32'h0000_0003); rd(12'h000); chk("R5 scratch when locked", rd_v, 32'h1);
  endtask

  task automatic t_keys;
    wr(12'h008, 32'h0000_DF0C); rd(12'h00C); chk("R3 wrong unlock key", rd_v, 32'h1);
    wr(12'h008, 32'hABCD_DF0D); rd(12'h00C); chk("R3 unlock key", rd_v, 32'h0);
    wr(12'h104, 32'h0000_CAFE);
    rd(12'h104); chk("R4 R11 unlocked write stored", rd_v, 32'h0000_CAFE);
    wr(12'h004, 32'h0000_767A); rd(12'h00C); chk("R2 wrong lock key", rd_v, 32'h0);
    wr(12'h004, 32'h5555_767B); rd(12'h00C); chk("R2 lock key", rd_v, 32'h1);
    wr(12'h104, 32'h0000_BEEF); rd(12'h104); chk("R4 relocked discards", rd_v, 32'h0000_CAFE);
  endtask

  task automatic t_softrst;
    wr(12'h200, 32'h1); chk("R6 no pulse when locked", 32'(wr_p), 32'h0);
    wr(12'h008, 32'h0000_DF0D);
    wr(12'h200, 32'h2); chk("R6 no pulse bit0 clear", 32'(wr_p), 32'h0);
    wr(12'h200, 32'h3); chk("R6 pulse", 32'(wr_p), 32'h1);
    @(negedge clk); chk("R6 pulse single cycle", 32'(soft_rst_req_o), 32'h0);
    rd(12'h200); chk("R6 reset ctrl stored", rd_v, 32'h3);
  endtask

  task automatic t_status;
    rd(12'h10C); chk("R7 pll status", rd_v, pll_stat_i); chk("R7 no err", 32'(rd_e), 32'h0);
    rd(12'h25C); chk("R7 boot mode", rd_v, boot_mode_i);
    rd(12'h530); chk("R7 id code", rd_v, id_code_i);
    rd(12'h618); chk("R7 ddr cmd", rd_v, ddr_cmd_stat_i);
    rd(12'h61C); chk("R7 ddr dfi", rd_v, ddr_dfi_stat_i);
    ddr_dfi_stat_i = 32'h0000_0077;
    rd(12'h61C); chk("R7 R11 live input", rd_v, 32'h77);
  endtask

  task automatic t_wo_err;
    rd(12'h004); chk("R8 wo read zero", rd_v, 32'h0); chk("R8 wo read err", 32'(rd_e), 32'h1);
    rd(12'h60C); chk("R8 cal read err", 32'(rd_e), 32'h1);
    rd(12'h614); chk("R8 ref read zero", rd_v, 32'h0);
    wr(12'h60C, 32'h1); chk("R8 cal write ok", 32'(wr_e), 32'h0);
    wr(12'h10C, 32'hFFFF); chk("R9 ro write err", 32'(wr_e), 32'h1);
    wr(12'h00C, 32'h1); chk("R9 lock sta write err", 32'(wr_e), 32'h1);
    rd(12'h00C); chk("R9 ro write no effect", rd_v, 32'h0);
    rd(12'h800); chk("R9 unmapped read err", 32'(rd_e), 32'h1); chk("R9 unmapped zero", rd_v, 32'h0);
    wr(12'h110, 32'h1); chk("R9 unmapped write err", 32'(wr_e), 32'h1);
  endtask

  task automatic t_pads;
    wr(12'h7D4, 32'h0000_ABCD); rd(12'h7D4); chk("R10 last pad rw", rd_v, 32'h0000_ABCD);
    rd(12'h7D8); chk("R10 past last pad err", 32'(rd_e), 32'h1);
    rd(12'h708); chk("R10 neighbour untouched", rd_v, 32'h0601);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #22 rst_n = 1;
    t_reset; t_locked; t_keys; t_softrst; t_status; t_wo_err; t_pads;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule